// File: doc/BRIEF.md
# Streaming Frame Syndrome Checker

The block watches a data frame that arrives as a fixed number of equal-width words and computes a 13-bit Hamming-style syndrome over every bit of the frame. The check bits stored in the frame are included in that sum. It never changes the data: it only reports. Any repair is left to logic downstream, which uses the reported bit position.

Each frame bit has a 1-based absolute position. A bit at index `b` (bit 0 is the word LSB) of the word at index `k` (the first word of the frame is index 0) sits at position `k*WORD_W + b + 1`. Every bit that is 1 XORs its position into the 12-bit location field. The top bit of the syndrome holds the parity of the whole frame. A frame whose contents match what was originally programmed therefore gives a syndrome of zero.

A single flipped bit, whether data or check, shows odd parity, and the location field gives its position. Two flips show even parity with a nonzero location field, and the block raises the error flag. The frame must hold fewer than 4096 bits. With the defaults it is 40 words of 32 bits, so 1280 bits.

Top module: `frame_ecc_syndrome`

## Requirements
- R1: For any frame, the reported syndrome has bit 12 equal to the XOR of all frame bits. Bits [11:0] equal the XOR of the 1-based positions of all bits that are 1, where a bit's position is word_index*WORD_W + bit_index + 1.
- R2: If a frame whose syndrome was zero has exactly one bit inverted at position p, the block reports syndrome = {1'b1, p}, single_err_o = 1 and error_o = 0.
- R3: If such a frame has exactly two bits inverted, the block reports syndrome[12] = 0 with syndrome[11:0] nonzero, error_o = 1 and single_err_o = 0. A syndrome of all zeros gives error_o = 0 and single_err_o = 0.
- R4: syn_valid_o is high for exactly one cycle. That cycle is the one after the clock edge that accepts the FRAME_WORDS-th word counted from the start-of-frame word. It is low at all other times.
- R5: syndrome_o, error_o and single_err_o hold their values from one frame completion until the next.
- R6: A word is accepted only when word_valid_i is high. A word with sof_i high starts a new frame and discards any partial one. Valid words that arrive while no frame is open are ignored.
- R7: When syndrome[12] = 1 and syndrome[11:0] is greater than the frame length in bits, the block reports error_o = 1 and single_err_o = 0.
- R8: When syndrome[12] = 1 and syndrome[11:0] = 0, this marks the overall parity itself as flipped. The block reports single_err_o = 1 and error_o = 0.
- R9: After reset, syndrome_o is 0, and syn_valid_o, error_o and single_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Marks the current valid word as word 0 of a frame |
| word_valid_i | input | 1 | Qualifies word_i and sof_i |
| word_i | input | WORD_W | Frame word |
| syndrome_o | output | 13 | Bit 12 is frame parity; bits [11:0] are the position XOR |
| syn_valid_o | output | 1 | One-cycle pulse when a frame has completed |
| error_o | output | 1 | Uncorrectable pattern detected |
| single_err_o | output | 1 | Single flip located by syndrome_o[11:0] |

## Verification
The assertions rely on these assumptions:
- reset holds for at least one clock;
- sof_i matters only while word_valid_i is high;
- a frame position never exceeds 4095.

The elaboration check enforces that last limit for every legal parameter set. The one-cycle pulse property is only built for frames of two or more words, since back-to-back one-word frames may pulse on every cycle.

The random stimulus keeps to whole frames of FRAME_WORDS words, with random idle gaps between words. Corner cases such as frames abandoned partway and stray words sent outside a frame are directed. Flipped positions are drawn from 1 to the frame length, so every located position is a real bit.

// File: rtl/ecc_frame_pkg.sv
package ecc_frame_pkg;
   localparam int POS_W = 12;
   localparam int SYN_W = POS_W + 1;
   localparam int MAX_FRAME_BITS = (1 << POS_W) - 1;

   typedef struct packed {
      logic             par;
      logic [POS_W-1:0] pos;
   } syn_t;
endpackage

// File: rtl/fsyn_word_xor.sv
module fsyn_word_xor
   import ecc_frame_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [IDX_W-1:0]  idx_i,
   output syn_t              contrib_o
);
   localparam bit W_POW2 = (WORD_W & (WORD_W - 1)) == 0;
   localparam int SHIFT  = (WORD_W > 1) ? $clog2(WORD_W) : 0;

   logic [POS_W-1:0] base;

   generate
      if (W_POW2) begin : g_shift_base
         assign base = POS_W'(32'(idx_i) << SHIFT);
      end else begin : g_mult_base
         assign base = POS_W'(32'(idx_i) * WORD_W);
      end
   endgenerate

   always_comb begin
      contrib_o = '0;
      for (int b = 0; b < WORD_W; b++) begin
         if (word_i[b]) begin
            contrib_o.pos = contrib_o.pos ^ (base + POS_W'(b + 1));
            contrib_o.par = ~contrib_o.par;
         end
      end
   end
endmodule

// File: rtl/fsyn_accum.sv
module fsyn_accum
   import ecc_frame_pkg::*;
#(
   parameter int FRAME_WORDS = 40,
   parameter int IDX_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_i,
   input  logic             word_valid_i,
   input  syn_t             contrib_i,
   output logic [IDX_W-1:0] idx_o,
   output syn_t             syn_o,
   output logic             done_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   syn_t             acc_q;
   syn_t             acc_base;
   syn_t             acc_next;
   logic             accept;
   logic             last_word;

   assign accept    = word_valid_i && (sof_i || active_q);
   assign idx_o     = sof_i ? '0 : idx_q;
   assign acc_base  = sof_i ? '0 : acc_q;
   assign acc_next  = acc_base ^ contrib_i;
   assign last_word = accept && (idx_o == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         acc_q    <= '0;
         syn_o    <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= last_word;
         if (accept) begin
            if (last_word) begin
               active_q <= 1'b0;
               idx_q    <= '0;
               acc_q    <= '0;
               syn_o    <= acc_next;
            end else begin
               active_q <= 1'b1;
               idx_q    <= idx_o + IDX_W'(1);
               acc_q    <= acc_next;
            end
         end
      end
   end

   // R5: the reported syndrome only changes together with the completion pulse
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(syn_o));

   // R6: the word counter never runs past the frame
   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX);

   // R6: with no open frame the counter is parked at word 0
   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> idx_q == '0);

   generate
      if (FRAME_WORDS > 1) begin : g_pulse_chk
         // R4: completion is a single-cycle pulse
         assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |=> !done_o);
      end
   endgenerate
endmodule

// File: rtl/fsyn_classify.sv
module fsyn_classify
   import ecc_frame_pkg::*;
#(
   parameter int FRAME_BITS = 1280
) (
   input  syn_t syn_i,
   output logic error_o,
   output logic single_o
);
   localparam logic [POS_W-1:0] LIMIT = POS_W'(FRAME_BITS);

   always_comb begin
      error_o  = 1'b0;
      single_o = 1'b0;
      if (syn_i.par) begin
         if (syn_i.pos > LIMIT) error_o  = 1'b1;
         else                   single_o = 1'b1;
      end else if (syn_i.pos != '0) begin
         error_o = 1'b1;
      end
   end
endmodule

// File: rtl/frame_ecc_syndrome.sv
module frame_ecc_syndrome
   import ecc_frame_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int FRAME_WORDS = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              word_valid_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [12:0]       syndrome_o,
   output logic              syn_valid_o,
   output logic              error_o,
   output logic              single_err_o
);
   localparam int FRAME_BITS = WORD_W * FRAME_WORDS;
   localparam int IDX_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

   generate
      if (WORD_W < 1 || FRAME_WORDS < 1) begin : g_bad_size
         $error("frame_ecc_syndrome: WORD_W and FRAME_WORDS must be at least 1");
      end
      if (FRAME_BITS > MAX_FRAME_BITS) begin : g_bad_len
         $error("frame_ecc_syndrome: frame must hold fewer than 4096 bits");
      end
   endgenerate

   syn_t             contrib;
   syn_t             syn_q;
   logic [IDX_W-1:0] idx;

   fsyn_word_xor #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_xor (
      .word_i    (word_i),
      .idx_i     (idx),
      .contrib_o (contrib)
   );

   fsyn_accum #(.FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W)) u_acc (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof_i        (sof_i),
      .word_valid_i (word_valid_i),
      .contrib_i    (contrib),
      .idx_o        (idx),
      .syn_o        (syn_q),
      .done_o       (syn_valid_o)
   );

   fsyn_classify #(.FRAME_BITS(FRAME_BITS)) u_cls (
      .syn_i    (syn_q),
      .error_o  (error_o),
      .single_o (single_err_o)
   );

   assign syndrome_o = syn_q;

   // R3: a clean syndrome raises neither flag
   assert_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      syndrome_o == '0 |-> !error_o && !single_err_o);

   // R3: even parity with a location present is uncorrectable
   assert_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!syndrome_o[12] && syndrome_o[11:0] != '0) |-> error_o && !single_err_o);

   // R7: a location outside the frame is never reported as correctable
   assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (syndrome_o[12] && syndrome_o[11:0] > 12'(FRAME_BITS)) |-> error_o && !single_err_o);

   // R8: parity-only flip is a located single error at position zero
   assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (syndrome_o[12] && syndrome_o[11:0] == '0) |-> single_err_o && !error_o);

   // R5: flags follow the held syndrome and do not move between completions
   assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_valid_o |-> $stable(error_o) && $stable(single_err_o));
endmodule

// File: tb/sim_frame_ecc_syndrome.sv
module sim_frame_ecc_syndrome;
   localparam int W = 32;
   localparam int N = 40;
   localparam int L = W * N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sof = 1'b0;
   logic          wv = 1'b0;
   logic [W-1:0]  wd = '0;
   logic [12:0]   syn;
   logic          svalid, err, sgl;

   int checks = 0;
   int fails  = 0;
   logic [W-1:0] frm [N];

   always #5 clk = ~clk;

   frame_ecc_syndrome #(.WORD_W(W), .FRAME_WORDS(N)) u0 (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .word_valid_i(wv), .word_i(wd),
      .syndrome_o(syn), .syn_valid_o(svalid), .error_o(err), .single_err_o(sgl)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [12:0] ref_syn();
      logic [12:0] s = '0;
      for (int k = 0; k < N; k++)
         for (int b = 0; b < W; b++)
            if (frm[k][b]) begin
               s[11:0] = s[11:0] ^ 12'(k * W + b + 1);
               s[12]   = ~s[12];
            end
      return s;
   endfunction

   task automatic flip(input int p);
      frm[(p - 1) / W][(p - 1) % W] = ~frm[(p - 1) / W][(p - 1) % W];
   endtask

   task automatic randomize_frame();
      for (int k = 0; k < N; k++) frm[k] = $urandom;
   endtask

   task automatic make_clean();
      logic [12:0] s;
      randomize_frame();
      for (int p = 1; p <= L; p = p * 2) frm[(p - 1) / W][(p - 1) % W] = 1'b0;
      s = ref_syn();
      for (int i = 0; i < 12; i++)
         if (s[i] && (1 << i) <= L) flip(1 << i);
      s = ref_syn();
      if (s[12]) begin
         flip(3); flip(1); flip(2);
      end
   endtask

   task automatic send(input int max_gap);
      for (int i = 0; i < N; i++) begin
         if (max_gap > 0) begin
            int g = $urandom_range(max_gap, 0);
            for (int j = 0; j < g; j++) begin
               @(negedge clk);
               wv = 1'b0; sof = 1'b0;
            end
         end
         @(negedge clk);
         if (i > 0) chk("R4 no pulse mid-frame", 32'(svalid), 32'd0);
         wv = 1'b1; sof = (i == 0); wd = frm[i];
      end
      @(negedge clk);
      wv = 1'b0; sof = 1'b0;
   endtask

   task automatic check_frame(input string req);
      logic [12:0] e = ref_syn();
      logic ee, es;
      ee = e[12] ? (32'(e[11:0]) > L) : (e[11:0] != 0);
      es = e[12] && (32'(e[11:0]) <= L);
      chk({req, " R4 valid pulse"}, 32'(svalid), 32'd1);
      chk({req, " syndrome"}, 32'(syn), 32'(e));
      chk({req, " error"}, 32'(err), 32'(ee));
      chk({req, " single"}, 32'(sgl), 32'(es));
      @(negedge clk);
      chk({req, " R4 pulse ends"}, 32'(svalid), 32'd0);
      chk({req, " R5 hold"}, 32'(syn), 32'(e));
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [12:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R9 reset syndrome", 32'(syn), 32'd0);
      chk("R9 reset valid", 32'(svalid), 32'd0);
      chk("R9 reset flags", {30'd0, err, sgl}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int t = 0; t < 3; t++) begin
         make_clean(); send(t);
         check_frame("R1 R3 clean");
         chk("R1 clean zero", 32'(syn), 32'd0);
      end

      for (int t = 0; t < 15; t++) begin
         randomize_frame(); send(2);
         check_frame("R1 random frame");
      end

      begin
         int plist[4] = '{1, L, 3, 1024};
         foreach (plist[i]) begin
            make_clean(); flip(plist[i]); send(0);
            check_frame("R2 directed single");
            chk("R2 position", 32'(syn), 32'({1'b1, 12'(plist[i])}));
         end
      end
      for (int t = 0; t < 15; t++) begin
         int p = $urandom_range(L, 1);
         make_clean(); flip(p); send(1);
         check_frame("R2 random single");
         chk("R2 located", {30'd0, sgl, err}, 32'd2);
      end

      for (int t = 0; t < 10; t++) begin
         int a = $urandom_range(L, 1);
         int b = $urandom_range(L, 1);
         if (b == a) b = (a % L) + 1;
         make_clean(); flip(a); flip(b); send(1);
         check_frame("R3 double");
         chk("R3 double error", {30'd0, err, sgl}, 32'd2);
         chk("R3 parity even", 32'(syn[12]), 32'd0);
      end

      make_clean(); flip(L); flip(1); flip(2); send(0);
      check_frame("R7 out of range");
      chk("R7 flags", {30'd0, err, sgl}, 32'd2);

      make_clean(); flip(1); flip(2); flip(3); send(0);
      check_frame("R8 parity only");
      chk("R8 flags", {30'd0, err, sgl}, 32'd1);

      // R6: stray words with no open frame leave the result untouched
      held = syn;
      for (int i = 0; i < N + 3; i++) begin
         @(negedge clk);
         wv = 1'b1; sof = 1'b0; wd = $urandom;
      end
      @(negedge clk);
      wv = 1'b0;
      chk("R6 stray no pulse", 32'(svalid), 32'd0);
      chk("R6 stray syndrome held", 32'(syn), 32'(held));

      // R6: a partial frame is discarded by a new start-of-frame
      for (int i = 0; i < N / 2; i++) begin
         @(negedge clk);
         wv = 1'b1; sof = (i == 0); wd = $urandom;
      end
      @(negedge clk);
      wv = 1'b0; sof = 1'b0; wd = '1;
      make_clean(); flip(77); send(3);
      check_frame("R6 restart");
      chk("R6 restart position", 32'(syn), 32'({1'b1, 12'd77}));

      // R6: sof without word_valid does not open a frame
      @(negedge clk);
      sof = 1'b1; wv = 1'b0;
      @(negedge clk);
      sof = 1'b0;
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         wv = 1'b1; wd = $urandom;
      end
      @(negedge clk);
      wv = 1'b0;
      chk("R6 unqualified sof ignored", 32'(svalid), 32'd0);

      // R5: long idle keeps the last result
      held = syn;
      repeat (50) @(negedge clk);
      chk("R5 idle hold syndrome", 32'(syn), 32'(held));
      chk("R5 idle hold flags", {30'd0, err, sgl}, 32'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule